// File: doc/BRIEF.md
# Disc Interface I/O Port Decoder

This block decodes the I/O cycles of an 8-bit Z80-style host bus for a disc and printer expansion interface. It looks at the low address byte and the active-low bus strobes, and produces active-low selects for a floppy disc controller, a drive control latch, a printer data latch and two joystick buffers. It also produces an active-low WAIT request that stalls the host while it writes to the network port and the network side reports that it is busy.

The decode is purely combinational, so every output follows the bus strobes directly. Each port carries a direction qualifier. Some ports answer only reads, some only writes, and the floppy controller answers both. Interrupt acknowledge cycles (M1 together with IORQ) never select anything. Addresses are compared on a masked basis. The floppy controller select ignores the two highest address bits, and every other port is fully decoded on all eight low bits.

Top module: `io_port_decoder`

## Requirements
- R1: `fdc_cs_no` is low during any I/O read or write whose address has A5=0, A4=1 and A3..A0=1011, whatever A7 and A6 are. This covers ports 0x1B, 0x5B, 0x9B and 0xDB.
- R2: `drv_stb_no` is low only during an I/O write to port 0x1F.
- R3: `prn_stb_no` is low only during an I/O write to port 0xFB.
- R4: `joy1_en_no` is low only during an I/O read of port 0x1F.
- R5: `joy2_en_no` is low only during an I/O read of port 0xFE.
- R6: `wait_no` is low only during an I/O write to port 0x3B while `net_busy_i` is 1. It stays high when `net_busy_i` is 0 and on reads of that port.
- R7: While `m1_ni` is low, every output is high for every address and strobe combination.
- R8: No output goes low for an address with A4 (addr_i[4]) = 0.
- R9: An I/O read is `iorq_ni`=0 with `rd_ni`=0, and an I/O write is `iorq_ni`=0 with `wr_ni`=0. With `iorq_ni` high, or with both `rd_ni` and `wr_ni` high, every output is high. Outputs follow the strobes with no clocking.
- R10: At most one of `fdc_cs_no`, `drv_stb_no`, `prn_stb_no`, `joy1_en_no` and `joy2_en_no` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 8 | Host address bits A7..A0 (bit i = Ai) |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| net_busy_i | input | 1 | Network transmitter busy, active high |
| fdc_cs_no | output | 1 | Floppy controller chip select, active low |
| drv_stb_no | output | 1 | Drive control latch strobe, active low |
| prn_stb_no | output | 1 | Printer data latch strobe, active low |
| joy1_en_no | output | 1 | First joystick buffer enable, active low |
| joy2_en_no | output | 1 | Second joystick buffer enable, active low |
| wait_no | output | 1 | Host WAIT request, active low |

## Verification
The assertions check the global properties whenever the inputs change: M1 suppresses every output, A4 low is never claimed, an idle bus claims nothing, at most one select is active, and WAIT needs network busy. Only the bench's sweep can show that each select lands on its exact port and direction. The sweep covers all 256 addresses under reads, writes, idle cycles and acknowledge cycles, with the network input both ways. It also confirms that the floppy select responds across all four A7/A6 aliases and that the shared port 0x1F splits cleanly between the read and write targets.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int ADDR_W  = 8;
  localparam int NUM_SEL = 5;

  typedef enum logic [1:0] {
    DIR_RD  = 2'd0,
    DIR_WR  = 2'd1,
    DIR_ANY = 2'd2
  } dir_e;

  typedef struct packed {
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] value;
    dir_e              dir;
  } port_rule_t;

  localparam int SEL_FDC  = 0;
  localparam int SEL_DRV  = 1;
  localparam int SEL_PRN  = 2;
  localparam int SEL_JOY1 = 3;
  localparam int SEL_JOY2 = 4;

  localparam port_rule_t WAIT_RULE = '{mask: 8'hFF, value: 8'h3B, dir: DIR_WR};

  function automatic port_rule_t rule_at(input int idx);
    port_rule_t r;
    case (idx)
      SEL_FDC:  r = '{mask: 8'h3F, value: 8'h1B, dir: DIR_ANY}; // A7/A6 free
      SEL_DRV:  r = '{mask: 8'hFF, value: 8'h1F, dir: DIR_WR};
      SEL_PRN:  r = '{mask: 8'hFF, value: 8'hFB, dir: DIR_WR};
      SEL_JOY1: r = '{mask: 8'hFF, value: 8'h1F, dir: DIR_RD};
      default:  r = '{mask: 8'hFF, value: 8'hFE, dir: DIR_RD};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/io_bus_qual.sv
module io_bus_qual (
  input  logic iorq_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic m1_ni,
  output logic rd_cyc_o,
  output logic wr_cyc_o
);
  logic io_cyc;

  // M1 with IORQ marks interrupt acknowledge: never a device cycle
  assign io_cyc   = !iorq_ni && m1_ni;
  assign rd_cyc_o = io_cyc && !rd_ni;
  assign wr_cyc_o = io_cyc && !wr_ni;

endmodule

// File: rtl/io_port_match.sv
module io_port_match
  import io_dec_pkg::*;
#(
  parameter port_rule_t RULE = '{mask: 8'hFF, value: 8'h00, dir: DIR_ANY}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_cyc_i,
  input  logic              wr_cyc_i,
  output logic              hit_o
);
  logic addr_ok;
  logic dir_ok;

  assign addr_ok = ((addr_i ^ RULE.value) & RULE.mask) == '0;

  generate
    if (RULE.dir == DIR_RD) begin : g_rd
      assign dir_ok = rd_cyc_i;
    end else if (RULE.dir == DIR_WR) begin : g_wr
      assign dir_ok = wr_cyc_i;
    end else begin : g_any
      assign dir_ok = rd_cyc_i || wr_cyc_i;
    end
  endgenerate

  assign hit_o = addr_ok && dir_ok;

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
(
  input  logic [7:0] addr_i,
  input  logic       iorq_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic       m1_ni,
  input  logic       net_busy_i,
  output logic       fdc_cs_no,
  output logic       drv_stb_no,
  output logic       prn_stb_no,
  output logic       joy1_en_no,
  output logic       joy2_en_no,
  output logic       wait_no
);
  logic               rd_cyc;
  logic               wr_cyc;
  logic [NUM_SEL-1:0] sel_hit;
  logic               net_hit;

  io_bus_qual u_qual (
    .iorq_ni  (iorq_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .m1_ni    (m1_ni),
    .rd_cyc_o (rd_cyc),
    .wr_cyc_o (wr_cyc)
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    io_port_match #(.RULE(rule_at(g))) u_match (
      .addr_i   (addr_i),
      .rd_cyc_i (rd_cyc),
      .wr_cyc_i (wr_cyc),
      .hit_o    (sel_hit[g])
    );
  end

  io_port_match #(.RULE(WAIT_RULE)) u_net (
    .addr_i   (addr_i),
    .rd_cyc_i (rd_cyc),
    .wr_cyc_i (wr_cyc),
    .hit_o    (net_hit)
  );

  assign fdc_cs_no  = !sel_hit[SEL_FDC];
  assign drv_stb_no = !sel_hit[SEL_DRV];
  assign prn_stb_no = !sel_hit[SEL_PRN];
  assign joy1_en_no = !sel_hit[SEL_JOY1];
  assign joy2_en_no = !sel_hit[SEL_JOY2];
  assign wait_no    = !(net_hit && net_busy_i);

  logic [5:0] outs_n;
  assign outs_n = {fdc_cs_no, drv_stb_no, prn_stb_no, joy1_en_no, joy2_en_no, wait_no};

  always_comb begin
    if (!$isunknown({addr_i, iorq_ni, rd_ni, wr_ni, m1_ni, net_busy_i})) begin
      if (!m1_ni) AST_M1_BLOCKS: assert (&outs_n);                               // R7
      if (!addr_i[4]) AST_A4_LOW_FREE: assert (&outs_n);                        // R8
      if (iorq_ni || (rd_ni && wr_ni)) AST_IDLE_FREE: assert (&outs_n);         // R9
      AST_ONE_SELECT: assert ($countones(~outs_n[5:1]) <= 1);                  // R10
      if (!net_busy_i) AST_WAIT_NEEDS_BUSY: assert (wait_no);                   // R6
      if (wr_ni) AST_WR_ONLY_QUIET: assert (drv_stb_no && prn_stb_no && wait_no); // R2
      if (rd_ni) AST_RD_ONLY_QUIET: assert (joy1_en_no && joy2_en_no);          // R4
    end
  end

endmodule

// File: tb/sim_io_port_decoder.sv
module sim_io_port_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1, busy = 1'b0;
  logic       fdc_n, drv_n, prn_n, j1_n, j2_n, wt_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_decoder u0 (
    .addr_i(addr), .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .m1_ni(m1_n),
    .net_busy_i(busy), .fdc_cs_no(fdc_n), .drv_stb_no(drv_n), .prn_stb_no(prn_n),
    .joy1_en_no(j1_n), .joy2_en_no(j2_n), .wait_no(wt_n)
  );

  // returns the tag of the requirement governing this output in this cycle
  function automatic string tag_for(input string base);
    if (!m1_n) return "R7";
    if (addr[4] == 1'b0) return "R8";
    if (iorq_n || (rd_n && wr_n)) return "R9";
    return base;
  endfunction

  task automatic cmp(input string name, input string base, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%02h iorq_n=%b rd_n=%b wr_n=%b m1_n=%b busy=%b act=%b exp=%b",
               tag_for(base), name, addr, iorq_n, rd_n, wr_n, m1_n, busy, act, exp);
    end
  endtask

  task automatic check_cycle();
    int  a;
    bit  rd, wr;
    logic e_fdc, e_drv, e_prn, e_j1, e_j2, e_wt;
    int  active;
    a  = int'(addr);
    rd = (iorq_n == 0) && (m1_n == 1) && (rd_n == 0);
    wr = (iorq_n == 0) && (m1_n == 1) && (wr_n == 0);
    e_fdc = !((rd || wr) && ((a % 64) == 27));
    e_drv = !(wr && a == 31);
    e_prn = !(wr && a == 251);
    e_j1  = !(rd && a == 31);
    e_j2  = !(rd && a == 254);
    e_wt  = !(wr && a == 59 && busy);
    @(negedge clk);
    cmp("fdc_cs",  "R1", fdc_n, e_fdc);
    cmp("drv_stb", "R2", drv_n, e_drv);
    cmp("prn_stb", "R3", prn_n, e_prn);
    cmp("joy1_en", "R4", j1_n,  e_j1);
    cmp("joy2_en", "R5", j2_n,  e_j2);
    cmp("wait",    "R6", wt_n,  e_wt);
    active = int'(!fdc_n) + int'(!drv_n) + int'(!prn_n) + int'(!j1_n) + int'(!j2_n);
    checks++;
    if (active > 1) begin
      errors++;
      $display("FAIL R10 overlap addr=%02h act=%0d exp<=1", addr, active);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic io_n, input logic r_n,
                       input logic w_n, input logic m_n, input logic b);
    @(posedge clk);
    addr = a; iorq_n = io_n; rd_n = r_n; wr_n = w_n; m1_n = m_n; busy = b;
    check_cycle();
  endtask

  initial begin
    // idle bus after start: all outputs inactive (R9)
    drive(8'h1B, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    // strobes without IORQ, and IORQ without strobes (R9)
    drive(8'h1F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    drive(8'hFB, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(8'h3B, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R6: network port write, busy then idle, then a read
    drive(8'h3B, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(8'h3B, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    drive(8'h3B, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    // R1: all four aliases, read and write
    for (int k = 0; k < 4; k++) begin
      drive(8'(k*64 + 27), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      drive(8'(k*64 + 27), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    end
    // R2/R4 share 0x1F; strobe drops when IORQ releases (R9)
    drive(8'h1F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    drive(8'h1F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    drive(8'h1F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // full sweep: read, write, ack cycle (R7), idle, both busy states
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 256; a++) begin
        drive(8'(a), 1'b0, 1'b0, 1'b1, 1'b1, 1'(b));
        drive(8'(a), 1'b0, 1'b1, 1'b0, 1'b1, 1'(b));
        drive(8'(a), 1'b0, 1'b0, 1'b1, 1'b0, 1'(b));
        drive(8'(a), 1'b0, 1'b1, 1'b0, 1'b0, 1'(b));
        drive(8'(a), 1'b1, 1'b1, 1'b1, 1'b1, 1'(b));
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule